// File: doc/BRIEF.md
# Paged Data Address Extender

This block sits between a processor core and its data RAM. The core always presents an 8-bit data offset, indirect pointers included, so on its own it can reach only a 256-byte window. For each access the core also says what kind it is: a direct operand, an indexed operand, a stack push or pop, or the read or the write half of a block move with post-increment. The block picks a page number for that access and places it above the offset to form an 11-bit physical RAM address.

Five 3-bit page registers supply the page numbers: the current page, the stack page, the index page, the move-source page and the move-destination page. A 2-bit paging mode, held in a flag register, decides which of them each kind of access uses. While the core services an interrupt, paging is switched off regardless of the mode bits. All six registers are written and read back through a small register port. The page selection logic is combinational, so a new page value applies to the first access after the clock edge that stores it.

Top module: `pgx_top`

## Requirements
- R1: After reset every page register and the mode field read back as zero, and every access maps to page 0.
- R2: Register port addresses: 0 current page, 1 stack page, 2 index page, 3 move-source page, 4 move-destination page, 5 flag register with the mode in bits [1:0]. A write stores only the low 3 bits of a page register or the low 2 bits of the flag register. Bits above those read back as zero.
- R3: A register write is stored on the rising clock edge. The physical address changes only after that edge.
- R4: In mode 0, every access kind maps to page 0.
- R5: In mode 1, indexed accesses use the stack page and direct accesses use page 0.
- R6: In mode 2, direct accesses use the current page and indexed accesses use the index page.
- R7: In mode 3, direct accesses use the current page and indexed accesses use the stack page.
- R8: While `irq_active` is high, every access maps to page 0 whatever the mode bits hold. The stored mode is not changed and still reads back.
- R9: In modes 1 to 3, stack accesses (kind code 2) use the stack page.
- R10: In modes 1 to 3, move reads (kind code 3) use the move-source page and move writes (kind code 4) use the move-destination page.
- R11: Writes to register addresses 6 and 7 change nothing, and reads from them return zero.
- R12: The physical address is the page in bits [10:8] above the unchanged offset in bits [7:0].
- R13: Access kind codes: 0 direct, 1 indexed, 2 stack, 3 move read, 4 move write. Codes 5 to 7 are routed as direct accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_active | input | 1 | Interrupt service in progress; forces no paging |
| acc_kind | input | 3 | Access kind code |
| acc_off | input | 8 | Data offset from the core |
| phys_addr | output | 11 | Physical RAM address |

## Verification
A page register that holds the wrong value shows up at `phys_addr` as soon as an access kind routed to it is presented, in the same cycle. A wrong mode or a wrong routing table needs the right combination of mode, interrupt state and kind before it becomes visible. For that reason the bench sweeps every mode, both interrupt states and all eight kind codes, using two sets of distinct page values. A write that lands at the wrong time or at the wrong address is caught by comparing the output just before and just after the storing edge, and by reading back every register after writes to the unmapped addresses.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

   localparam int unsigned RA_W    = 3;
   localparam int unsigned NUM_PG  = 5;

   localparam int unsigned PG_CUR  = 0;
   localparam int unsigned PG_STK  = 1;
   localparam int unsigned PG_IDX  = 2;
   localparam int unsigned PG_MRD  = 3;
   localparam int unsigned PG_MWR  = 4;
   localparam int unsigned REG_FLAG = 5;

   typedef enum logic [2:0] {
      ACC_DIR = 3'd0,
      ACC_IDX = 3'd1,
      ACC_STK = 3'd2,
      ACC_MRD = 3'd3,
      ACC_MWR = 3'd4
   } acc_e;

   typedef enum logic [1:0] {
      MODE_FLAT   = 2'd0,
      MODE_STKALL = 2'd1,
      MODE_SPLIT  = 2'd2,
      MODE_IDXSTK = 2'd3
   } pmode_e;

endpackage

// File: rtl/pgx_regs.sv
module pgx_regs
   import pgx_pkg::*;
#(
   parameter int unsigned PG_W = 3,
   parameter int unsigned DW   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [RA_W-1:0]          waddr,
   input  logic [DW-1:0]            wdata,
   input  logic [RA_W-1:0]          raddr,
   output logic [DW-1:0]            rdata,
   output logic [NUM_PG*PG_W-1:0]   pages_flat,
   output logic [1:0]               mode
);

   localparam int unsigned MODE_W = 2;

   if (PG_W < 1 || PG_W > DW) begin : g_bad_pg_w
      $error("pgx_regs: PG_W must lie in 1..DW");
   end
   if (DW < MODE_W) begin : g_bad_dw
      $error("pgx_regs: DW too small for mode field");
   end

   logic [PG_W-1:0] pg_q [NUM_PG];
   logic            unused_wdata;

   assign unused_wdata = ^wdata;

   for (genvar g = 0; g < NUM_PG; g++) begin : g_page
      always_ff @(posedge clk) begin
         if (!rst_n)
            pg_q[g] <= '0;
         else if (we && (waddr == RA_W'(g)))
            pg_q[g] <= wdata[PG_W-1:0];
      end

      assign pages_flat[g*PG_W +: PG_W] = pg_q[g];

      // R3: a write to this page register is stored at the next edge
      a_r3_page_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
         (we && waddr == RA_W'(g)) |=> (pages_flat[g*PG_W +: PG_W] == $past(wdata[PG_W-1:0])));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode <= '0;
      else if (we && (waddr == RA_W'(REG_FLAG)))
         mode <= wdata[MODE_W-1:0];
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_PG; i++) begin
         if (raddr == RA_W'(i))
            rdata[PG_W-1:0] = pg_q[i];
      end
      if (raddr == RA_W'(REG_FLAG))
         rdata[MODE_W-1:0] = mode;
   end

   // R11: writes to unmapped addresses leave all state unchanged
   a_r11_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr > RA_W'(REG_FLAG)) |=> ($stable(pages_flat) && $stable(mode)));

   // R2: flag write stores the low mode bits
   a_r2_flag_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == RA_W'(REG_FLAG)) |=> (mode == $past(wdata[MODE_W-1:0])));

endmodule

// File: rtl/pgx_sel.sv
module pgx_sel
   import pgx_pkg::*;
#(
   parameter int unsigned PG_W = 3
) (
   input  logic                     irq_active,
   input  logic [1:0]               mode,
   input  logic [2:0]               kind,
   input  logic [NUM_PG*PG_W-1:0]   pages_flat,
   output logic [PG_W-1:0]          page
);

   pmode_e          eff_mode;
   acc_e            kind_e;
   logic [PG_W-1:0] cur_pg, stk_pg, idx_pg, mrd_pg, mwr_pg;

   assign cur_pg = pages_flat[PG_CUR*PG_W +: PG_W];
   assign stk_pg = pages_flat[PG_STK*PG_W +: PG_W];
   assign idx_pg = pages_flat[PG_IDX*PG_W +: PG_W];
   assign mrd_pg = pages_flat[PG_MRD*PG_W +: PG_W];
   assign mwr_pg = pages_flat[PG_MWR*PG_W +: PG_W];

   assign eff_mode = irq_active ? MODE_FLAT : pmode_e'(mode);
   assign kind_e   = acc_e'(kind);

   always_comb begin
      page = '0;
      if (eff_mode != MODE_FLAT) begin
         case (kind_e)
            ACC_STK: page = stk_pg;
            ACC_MRD: page = mrd_pg;
            ACC_MWR: page = mwr_pg;
            ACC_IDX: page = (eff_mode == MODE_SPLIT) ? idx_pg : stk_pg;
            default: page = (eff_mode == MODE_STKALL) ? '0 : cur_pg;
         endcase
      end
   end

endmodule

// File: rtl/pgx_top.sv
module pgx_top
   import pgx_pkg::*;
#(
   parameter int unsigned OFS_W = 8,
   parameter int unsigned PG_W  = 3,
   parameter int unsigned DW    = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_we,
   input  logic [2:0]              reg_waddr,
   input  logic [DW-1:0]           reg_wdata,
   input  logic [2:0]              reg_raddr,
   output logic [DW-1:0]           reg_rdata,
   input  logic                    irq_active,
   input  logic [2:0]              acc_kind,
   input  logic [OFS_W-1:0]        acc_off,
   output logic [PG_W+OFS_W-1:0]   phys_addr
);

   localparam int unsigned PA_W = PG_W + OFS_W;

   if (OFS_W < 1) begin : g_bad_ofs
      $error("pgx_top: OFS_W must be positive");
   end

   logic [NUM_PG*PG_W-1:0] pages_flat;
   logic [1:0]             mode;
   logic [PG_W-1:0]        page;

   pgx_regs #(.PG_W(PG_W), .DW(DW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (reg_we),
      .waddr      (reg_waddr),
      .wdata      (reg_wdata),
      .raddr      (reg_raddr),
      .rdata      (reg_rdata),
      .pages_flat (pages_flat),
      .mode       (mode)
   );

   pgx_sel #(.PG_W(PG_W)) u_sel (
      .irq_active (irq_active),
      .mode       (mode),
      .kind       (acc_kind),
      .pages_flat (pages_flat),
      .page       (page)
   );

   assign phys_addr = {page, acc_off};

   // R4 / R8: no paging in mode 0 or during interrupt service
   a_r8_flat_when_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_active || mode == 2'd0) |-> (phys_addr[PA_W-1:OFS_W] == '0));

   // R9: stack accesses follow the stack page when paging is on
   a_r9_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_active && mode != 2'd0 && acc_kind == 3'd2)
         |-> (phys_addr[PA_W-1:OFS_W] == pages_flat[PG_STK*PG_W +: PG_W]));

   // R10: move halves use their own pages
   a_r10_move_pages: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_active && mode != 2'd0 && acc_kind == 3'd4)
         |-> (phys_addr[PA_W-1:OFS_W] == pages_flat[PG_MWR*PG_W +: PG_W]));

   // R12: offset passes through untouched
   a_r12_offset_through: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[OFS_W-1:0] == acc_off);

endmodule

// File: tb/tb_pgx_top.sv
module tb_pgx_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_waddr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [2:0]  reg_raddr = '0;
   logic [7:0]  reg_rdata;
   logic        irq_active = 1'b0;
   logic [2:0]  acc_kind = '0;
   logic [7:0]  acc_off = '0;
   logic [10:0] phys_addr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pgx_top dut (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .irq_active(irq_active), .acc_kind(acc_kind), .acc_off(acc_off),
      .phys_addr(phys_addr)
   );

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_we = 1'b1; reg_waddr = 3'(a); reg_wdata = 8'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int a, input int exp);
      reg_raddr = 3'(a);
      #1;
      chk(req, int'(reg_rdata), exp);
   endtask

   function automatic int exp_page(input int md, input bit irq, input int kind,
                                   input int cur, input int stk, input int idx,
                                   input int mrd, input int mwr);
      if (irq || md == 0) return 0;
      case (kind)
         1: return (md == 2) ? idx : stk;
         2: return stk;
         3: return mrd;
         4: return mwr;
         default: return (md == 1) ? 0 : cur;
      endcase
   endfunction

   task automatic sweep(input int cur, input int stk, input int idx,
                        input int mrd, input int mwr);
      int offs [3] = '{8'h00, 8'h5A, 8'hFF};
      wr(0, cur); wr(1, stk); wr(2, idx); wr(3, mrd); wr(4, mwr);
      for (int md = 0; md < 4; md++) begin
         wr(5, md);
         for (int irq = 0; irq < 2; irq++) begin
            for (int k = 0; k < 8; k++) begin
               for (int o = 0; o < 3; o++) begin
                  string req;
                  int pg;
                  @(negedge clk);
                  irq_active = irq[0];
                  acc_kind = 3'(k);
                  acc_off = 8'(offs[o]);
                  #1;
                  if (irq != 0)      req = "R8";
                  else if (md == 0)  req = "R4";
                  else if (md == 1)  req = "R5";
                  else if (md == 2)  req = "R6";
                  else               req = "R7";
                  if (k == 2) req = {req, "/R9"};
                  if (k == 3 || k == 4) req = {req, "/R10"};
                  if (k > 4) req = {req, "/R13"};
                  req = {req, "/R12"};
                  pg = exp_page(md, irq[0], k, cur, stk, idx, mrd, mwr);
                  chk(req, int'(phys_addr), (pg << 8) | offs[o]);
               end
            end
            if (irq != 0) rd_chk("R8 mode kept", 5, md);
         end
      end
      irq_active = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 6; a++) rd_chk("R1 reg", a, 0);
      acc_off = 8'h3C;
      for (int k = 0; k < 5; k++) begin
         acc_kind = 3'(k);
         #1;
         chk("R1 phys", int'(phys_addr), 8'h3C);
      end

      // R2: only the low bits stored
      wr(2, 8'hFD);
      rd_chk("R2 idx low bits", 2, 5);
      wr(5, 8'hFE);
      rd_chk("R2 flag low bits", 5, 2);

      // R3: write timing, mode 2 direct access to current page
      wr(0, 1);
      @(negedge clk);
      acc_kind = 3'd0; acc_off = 8'h11; irq_active = 1'b0;
      reg_we = 1'b1; reg_waddr = 3'd0; reg_wdata = 8'd6;
      #1;
      chk("R3 before edge", int'(phys_addr), (1 << 8) | 8'h11);
      @(posedge clk);
      #1;
      reg_we = 1'b0;
      chk("R3 after edge", int'(phys_addr), (6 << 8) | 8'h11);

      // R11: unmapped writes ignored, unmapped reads zero
      wr(1, 3); wr(3, 4); wr(4, 7);
      wr(6, 8'hFF);
      wr(7, 8'hFF);
      rd_chk("R11 cur kept", 0, 6);
      rd_chk("R11 stk kept", 1, 3);
      rd_chk("R11 idx kept", 2, 5);
      rd_chk("R11 mrd kept", 3, 4);
      rd_chk("R11 mwr kept", 4, 7);
      rd_chk("R11 flag kept", 5, 2);
      rd_chk("R11 read 6", 6, 0);
      rd_chk("R11 read 7", 7, 0);

      // R4..R10, R12, R13: full sweeps with two page sets
      sweep(1, 2, 3, 4, 5);
      sweep(6, 5, 7, 1, 3);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule